// File: doc/BRIEF.md
# Timer Byte-Bus Register Bank

This block sits between an 8-bit register bus and a 16-bit timer core. It holds the timer's three control bytes, the capture/top register and a set of compare registers. It also owns the interrupt mask and interrupt flag bytes. The counter itself lives in the core. This bank reads the counter through a live input and hands back a load strobe with a 16-bit value when software rewrites it.

Each 16-bit quantity wider than the bus is moved through a single shared high-byte staging latch, so that software always sees or writes a coherent 16-bit value:

- On reads, the low byte goes first and the high byte is taken from the staging latch.
- On writes, the high byte goes first and the low byte commits both halves in one cycle.

The capture/top register accepts writes only while the timer is in its capture-top clear mode. A bus region select picks the main timer window, the mask byte or the flag byte.

Top module: `tmr16_regbank`

## Requirements
- R1: After a synchronous reset every stored byte, the staging latch, `bus_rdata`, `irq_mask_o`, `irq_flag_o`, `cap_val_o` and `cmp_val_o` are zero, and `cnt_wr_o`, `flag_wr_o` and `force_o` are low.
- R2: In region 0, offset 0x0 is control byte A and offset 0x1 is control byte B, both fully read/write. `mode_o` equals {B[4:3], A[1:0]}.
- R3: Control byte C sits at offset 0x2. Bits 7, 6 and 5 are force strobes for compare channels 0, 1 and 2 (`force_o[0]`, `force_o[1]`, `force_o[2]`). Writing a 1 there raises the matching `force_o` bit for exactly the cycle after the write. Those bits always read back 0, while bits 4:0 are stored.
- R4: A read of offset 0x4 returns `cnt_live[7:0]` and copies `cnt_live[15:8]` into the staging latch. A read of offset 0x5 returns the staging latch, whatever the live counter does in between.
- R5: A write to offset 0x5 only loads the staging latch. A write to offset 0x4 pulses `cnt_wr_o` for one cycle with `cnt_wdata_o` = {staging latch, written byte}.
- R6: Offsets 0x6/0x7 hold the capture/top register and follow the same low/high ordering through the same staging latch:
  - a low read latches the high byte;
  - a high write loads the latch;
  - a low write commits {latch, byte}.
- R7: While `mode_o` is not 12, writes to offsets 0x6 and 0x7 change neither the capture/top register nor the staging latch.
- R8: Compare channel k occupies offsets 0x8+2k (low byte) and 0x9+2k (high byte), read and written directly without the staging latch. `cmp_val_o[16k+15:16k]` holds its value.
- R9: Region 1, offset 0 is the interrupt mask byte. Only bits 0 (overflow), 1..3 (compare channels 0..2) and 5 (capture) are stored, and the other bits read as 0.
- R10: Region 2, offset 0 is the interrupt flag byte. A bit is set when `flag_set` has that bit high. A bus write replaces the stored bits (restricted to the R9 bit set), with `flag_set` taking precedence, and pulses `flag_wr_o` for one cycle.
- R11: Reads of unmapped locations return 0, and writes to them change no state. Unmapped locations are:
  - offsets 0x3, 0xE and 0xF of region 0;
  - any non-zero offset of regions 1 and 2;
  - all of region 3.
- R12: `bus_rdata` is registered. It presents the read data in the cycle after `bus_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rgn | input | 2 | Region: 0 timer window, 1 mask, 2 flag, 3 none |
| bus_addr | input | AW (4) | Byte offset within region |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Registered read data |
| cnt_live | input | 2*DW (16) | Live counter value from the core |
| flag_set | input | DW (8) | Per-bit flag set requests from the core |
| ctrl_a_o | output | DW (8) | Control byte A |
| ctrl_b_o | output | DW (8) | Control byte B |
| ctrl_c_o | output | DW (8) | Control byte C, force bits zero |
| mode_o | output | 4 | Timer mode field |
| force_o | output | NCMP (3) | One-cycle force-compare pulses |
| cnt_wr_o | output | 1 | Counter load strobe |
| cnt_wdata_o | output | 2*DW (16) | Counter load value |
| cap_val_o | output | 2*DW (16) | Capture/top register |
| cmp_val_o | output | NCMP*2*DW (48) | Compare registers, channel 0 in low bits |
| irq_mask_o | output | DW (8) | Interrupt mask byte |
| irq_flag_o | output | DW (8) | Interrupt flag byte |
| flag_wr_o | output | 1 | Pulse on a bus write of the flag byte |

## Verification
The staging latch is the one piece of state that cannot be seen directly. A corrupt latch shows up only on the next access that consumes it:
- a high-byte read of the counter or capture register returns the wrong byte one cycle after that read;
- a counter load carries the wrong upper byte on `cnt_wdata_o` in the cycle after the low write.

The bench therefore interleaves counter and capture accesses and changes the live counter between low and high reads. A wrongly gated capture write shows up immediately on `cap_val_o`. A stray force bit shows up immediately on `force_o` and on the control C readback.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef enum logic [1:0] {
    RGN_TMR  = 2'd0,
    RGN_MSK  = 2'd1,
    RGN_FLG  = 2'd2,
    RGN_NONE = 2'd3
  } rgn_e;

  localparam logic [3:0] OFS_CTLA   = 4'h0;
  localparam logic [3:0] OFS_CTLB   = 4'h1;
  localparam logic [3:0] OFS_CTLC   = 4'h2;
  localparam logic [3:0] OFS_CNT_LO = 4'h4;
  localparam logic [3:0] OFS_CNT_HI = 4'h5;
  localparam logic [3:0] OFS_CAP_LO = 4'h6;
  localparam logic [3:0] OFS_CAP_HI = 4'h7;
  localparam int unsigned OFS_CMP_BASE = 8;

  // mode field bit positions inside control bytes
  localparam int unsigned MODE_A_LSB = 0;
  localparam int unsigned MODE_B_LSB = 3;
  // force strobe for channel k sits at bit FORCE_MSB-k
  localparam int unsigned FORCE_MSB  = 7;

  localparam int unsigned IRQ_OVF  = 0;
  localparam int unsigned IRQ_CMP0 = 1;
  localparam int unsigned IRQ_CAP  = 5;

  function automatic logic [7:0] irq_valid_bits(input int unsigned ncmp);
    logic [7:0] m;
    m = '0;
    m[IRQ_OVF] = 1'b1;
    m[IRQ_CAP] = 1'b1;
    for (int k = 0; k < ncmp; k++) m[IRQ_CMP0 + k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tmr16_ctrl_regs.sv
module tmr16_ctrl_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NCMP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_a,
  input  logic            wr_b,
  input  logic            wr_c,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   ctrl_a,
  output logic [DW-1:0]   ctrl_b,
  output logic [DW-1:0]   ctrl_c,
  output logic [3:0]      mode,
  output logic [NCMP-1:0] force_p
);
  localparam int unsigned FORCE_LSB = FORCE_MSB - NCMP + 1;

  logic [DW-1:0] c_keep;

  // bits that store; force positions never do
  always_comb begin
    c_keep = '1;
    for (int k = 0; k < NCMP; k++) c_keep[FORCE_MSB - k] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
      ctrl_c <= '0;
    end else begin
      if (wr_a) ctrl_a <= wdata;
      if (wr_b) ctrl_b <= wdata;
      if (wr_c) ctrl_c <= wdata & c_keep;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCMP; g++) begin : g_force
      always_ff @(posedge clk) begin
        if (rst) force_p[g] <= 1'b0;
        else     force_p[g] <= wr_c & wdata[FORCE_MSB - g];
      end
    end
  endgenerate

  assign mode = {ctrl_b[MODE_B_LSB +: 2], ctrl_a[MODE_A_LSB +: 2]};

  logic unused_lsb;
  assign unused_lsb = (FORCE_LSB == 0);
endmodule

// File: rtl/tmr16_wide_regs.sv
module tmr16_wide_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned NCMP     = 3,
  parameter int unsigned MODE_ICR = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           mode,
  input  logic                 rd_cnt_lo,
  input  logic                 rd_cap_lo,
  input  logic                 wr_cnt_lo,
  input  logic                 wr_cnt_hi,
  input  logic                 wr_cap_lo,
  input  logic                 wr_cap_hi,
  input  logic [NCMP-1:0]      wr_cmp_lo,
  input  logic [NCMP-1:0]      wr_cmp_hi,
  input  logic [DW-1:0]        wdata,
  input  logic [2*DW-1:0]      cnt_live,
  output logic [DW-1:0]        stage,
  output logic [2*DW-1:0]      cap_val,
  output logic [NCMP*2*DW-1:0] cmp_val,
  output logic                 cnt_wr,
  output logic [2*DW-1:0]      cnt_wdata
);
  localparam int unsigned WW = 2 * DW;

  logic cap_open;
  assign cap_open = (mode == 4'(MODE_ICR));

  // shared staging latch: writes win over read-side captures
  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
    end else if (wr_cnt_hi || (wr_cap_hi && cap_open)) begin
      stage <= wdata;
    end else if (rd_cnt_lo) begin
      stage <= cnt_live[WW-1:DW];
    end else if (rd_cap_lo) begin
      stage <= cap_val[WW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
    end else if (wr_cap_lo && cap_open) begin
      cap_val <= {stage, wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_wr    <= 1'b0;
      cnt_wdata <= '0;
    end else begin
      cnt_wr <= wr_cnt_lo;
      if (wr_cnt_lo) cnt_wdata <= {stage, wdata};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCMP; g++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst) begin
          cmp_val[g*WW +: WW] <= '0;
        end else begin
          if (wr_cmp_lo[g]) cmp_val[g*WW +: DW]      <= wdata;
          if (wr_cmp_hi[g]) cmp_val[g*WW + DW +: DW] <= wdata;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tmr16_irq_regs.sv
module tmr16_irq_regs
  import tmr16_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NCMP = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mask,
  input  logic          wr_flag,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] flag_set,
  output logic [DW-1:0] irq_mask,
  output logic [DW-1:0] irq_flag,
  output logic          flag_wr
);
  localparam logic [7:0] VALID8 = irq_valid_bits(NCMP);
  localparam logic [DW-1:0] VALID = DW'(VALID8);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_mask <= '0;
      irq_flag <= '0;
      flag_wr  <= 1'b0;
    end else begin
      if (wr_mask) irq_mask <= wdata & VALID;
      irq_flag <= ((wr_flag ? wdata : irq_flag) | flag_set) & VALID;
      flag_wr  <= wr_flag;
    end
  end
endmodule

// File: rtl/tmr16_regbank.sv
module tmr16_regbank
  import tmr16_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned NCMP     = 3,
  parameter int unsigned MODE_ICR = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           bus_rgn,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [2*DW-1:0]      cnt_live,
  input  logic [DW-1:0]        flag_set,
  output logic [DW-1:0]        ctrl_a_o,
  output logic [DW-1:0]        ctrl_b_o,
  output logic [DW-1:0]        ctrl_c_o,
  output logic [3:0]           mode_o,
  output logic [NCMP-1:0]      force_o,
  output logic                 cnt_wr_o,
  output logic [2*DW-1:0]      cnt_wdata_o,
  output logic [2*DW-1:0]      cap_val_o,
  output logic [NCMP*2*DW-1:0] cmp_val_o,
  output logic [DW-1:0]        irq_mask_o,
  output logic [DW-1:0]        irq_flag_o,
  output logic                 flag_wr_o
);
  localparam int unsigned WW = 2 * DW;

  rgn_e rgn;
  assign rgn = rgn_e'(bus_rgn);

  logic in_tmr, at_zero;
  assign in_tmr  = (rgn == RGN_TMR);
  assign at_zero = (bus_addr == '0);

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned ofs);
    return a == AW'(ofs);
  endfunction

  // write decode
  logic w_a, w_b, w_c, w_cl, w_ch, w_pl, w_ph, w_msk, w_flg;
  logic r_cl, r_pl;
  logic [NCMP-1:0] w_ml, w_mh;

  assign w_a   = bus_wr && in_tmr && hit(bus_addr, OFS_CTLA);
  assign w_b   = bus_wr && in_tmr && hit(bus_addr, OFS_CTLB);
  assign w_c   = bus_wr && in_tmr && hit(bus_addr, OFS_CTLC);
  assign w_cl  = bus_wr && in_tmr && hit(bus_addr, OFS_CNT_LO);
  assign w_ch  = bus_wr && in_tmr && hit(bus_addr, OFS_CNT_HI);
  assign w_pl  = bus_wr && in_tmr && hit(bus_addr, OFS_CAP_LO);
  assign w_ph  = bus_wr && in_tmr && hit(bus_addr, OFS_CAP_HI);
  assign w_msk = bus_wr && (rgn == RGN_MSK) && at_zero;
  assign w_flg = bus_wr && (rgn == RGN_FLG) && at_zero;
  assign r_cl  = bus_rd && in_tmr && hit(bus_addr, OFS_CNT_LO);
  assign r_pl  = bus_rd && in_tmr && hit(bus_addr, OFS_CAP_LO);

  genvar g;
  generate
    for (g = 0; g < NCMP; g++) begin : g_dec
      assign w_ml[g] = bus_wr && in_tmr && hit(bus_addr, OFS_CMP_BASE + 2*g);
      assign w_mh[g] = bus_wr && in_tmr && hit(bus_addr, OFS_CMP_BASE + 2*g + 1);
    end
  endgenerate

  logic [DW-1:0] stage;

  tmr16_ctrl_regs #(.DW(DW), .NCMP(NCMP)) ctrl_i (
    .clk(clk), .rst(rst),
    .wr_a(w_a), .wr_b(w_b), .wr_c(w_c), .wdata(bus_wdata),
    .ctrl_a(ctrl_a_o), .ctrl_b(ctrl_b_o), .ctrl_c(ctrl_c_o),
    .mode(mode_o), .force_p(force_o)
  );

  tmr16_wide_regs #(.DW(DW), .NCMP(NCMP), .MODE_ICR(MODE_ICR)) wide_i (
    .clk(clk), .rst(rst), .mode(mode_o),
    .rd_cnt_lo(r_cl), .rd_cap_lo(r_pl),
    .wr_cnt_lo(w_cl), .wr_cnt_hi(w_ch),
    .wr_cap_lo(w_pl), .wr_cap_hi(w_ph),
    .wr_cmp_lo(w_ml), .wr_cmp_hi(w_mh),
    .wdata(bus_wdata), .cnt_live(cnt_live),
    .stage(stage), .cap_val(cap_val_o), .cmp_val(cmp_val_o),
    .cnt_wr(cnt_wr_o), .cnt_wdata(cnt_wdata_o)
  );

  tmr16_irq_regs #(.DW(DW), .NCMP(NCMP)) irq_i (
    .clk(clk), .rst(rst),
    .wr_mask(w_msk), .wr_flag(w_flg), .wdata(bus_wdata),
    .flag_set(flag_set),
    .irq_mask(irq_mask_o), .irq_flag(irq_flag_o), .flag_wr(flag_wr_o)
  );

  // read mux
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (rgn)
      RGN_TMR: begin
        if      (hit(bus_addr, OFS_CTLA))   rd_mux = ctrl_a_o;
        else if (hit(bus_addr, OFS_CTLB))   rd_mux = ctrl_b_o;
        else if (hit(bus_addr, OFS_CTLC))   rd_mux = ctrl_c_o;
        else if (hit(bus_addr, OFS_CNT_LO)) rd_mux = cnt_live[DW-1:0];
        else if (hit(bus_addr, OFS_CNT_HI)) rd_mux = stage;
        else if (hit(bus_addr, OFS_CAP_LO)) rd_mux = cap_val_o[DW-1:0];
        else if (hit(bus_addr, OFS_CAP_HI)) rd_mux = stage;
        for (int k = 0; k < NCMP; k++) begin
          if (hit(bus_addr, OFS_CMP_BASE + 2*k))
            rd_mux = cmp_val_o[k*WW +: DW];
          if (hit(bus_addr, OFS_CMP_BASE + 2*k + 1))
            rd_mux = cmp_val_o[k*WW + DW +: DW];
        end
      end
      RGN_MSK:  rd_mux = at_zero ? irq_mask_o : '0;
      RGN_FLG:  rd_mux = at_zero ? irq_flag_o : '0;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr16_regbank_chk.sv
module tmr16_regbank_chk #(
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 4,
  parameter int unsigned NCMP     = 3,
  parameter int unsigned MODE_ICR = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           bus_rgn,
  input logic [AW-1:0]        bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [DW-1:0]        bus_rdata,
  input logic [2*DW-1:0]      cnt_live,
  input logic [3:0]           mode_o,
  input logic                 cnt_wr_o,
  input logic [2*DW-1:0]      cap_val_o,
  input logic                 flag_wr_o
);
  AST_CNT_LOAD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_o |-> $past(bus_wr && bus_rgn == 2'd0 && bus_addr == AW'(4))); // R5

  AST_CNT_LO_LIVE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_rgn == 2'd0 && bus_addr == AW'(4)) |=> (bus_rdata == $past(cnt_live[DW-1:0]))); // R4

  AST_FORCE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_rgn == 2'd0 && bus_addr == AW'(2)) |=> (bus_rdata[7:5] == 3'b000)); // R3

  AST_CAP_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 4'(MODE_ICR)) |=> $stable(cap_val_o)); // R7

  AST_FLAG_WR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    flag_wr_o |-> $past(bus_wr && bus_rgn == 2'd2 && bus_addr == '0)); // R10

  AST_HOLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_rgn == 2'd0 && bus_addr == AW'(3)) |=> (bus_rdata == '0)); // R11

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R12
endmodule

bind tmr16_regbank tmr16_regbank_chk #(
  .DW(DW), .AW(AW), .NCMP(NCMP), .MODE_ICR(MODE_ICR)
) chk_i (
  .clk(clk), .rst(rst), .bus_rgn(bus_rgn), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .cnt_live(cnt_live), .mode_o(mode_o), .cnt_wr_o(cnt_wr_o),
  .cap_val_o(cap_val_o), .flag_wr_o(flag_wr_o)
);

// File: tb/tmr16_regbank_tb_top.sv
module tmr16_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_rgn = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_live = '0;
  logic [7:0]  flag_set = '0;
  logic [7:0]  ctrl_a_o, ctrl_b_o, ctrl_c_o, irq_mask_o, irq_flag_o;
  logic [3:0]  mode_o;
  logic [2:0]  force_o;
  logic        cnt_wr_o, flag_wr_o;
  logic [15:0] cnt_wdata_o, cap_val_o;
  logic [47:0] cmp_val_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tmr16_regbank dut_i (
    .clk(clk), .rst(rst), .bus_rgn(bus_rgn), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt_live(cnt_live), .flag_set(flag_set),
    .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o), .ctrl_c_o(ctrl_c_o),
    .mode_o(mode_o), .force_o(force_o), .cnt_wr_o(cnt_wr_o),
    .cnt_wdata_o(cnt_wdata_o), .cap_val_o(cap_val_o), .cmp_val_o(cmp_val_o),
    .irq_mask_o(irq_mask_o), .irq_flag_o(irq_flag_o), .flag_wr_o(flag_wr_o)
  );

  // scoreboard for bus reads
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 64'd1, 64'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {56'd0, bus_rdata}, {56'd0, e});
      end
    end
  end

  task automatic bwrite(input logic [1:0] rg, input logic [3:0] a, input logic [7:0] d);
    bus_rgn = rg; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [1:0] rg, input logic [3:0] a,
                       input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rgn = rg; bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog expired", 64'd1, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 cnt_wr", cnt_wr_o, 0);
    check("R1 flag", irq_flag_o, 0);
    check("R1 cap", cap_val_o, 0);
    check("R1 cmp", cmp_val_o, 0);
    check("R1 force", force_o, 0);
    bread(2'd0, 4'h0, 8'h00, "R1 ctrl A reset");
    bread(2'd0, 4'h5, 8'h00, "R1 staging reset");

    // R2 control A/B and mode
    bwrite(2'd0, 4'h0, 8'hA5);
    bwrite(2'd0, 4'h1, 8'h3C);
    bread(2'd0, 4'h0, 8'hA5, "R2 ctrl A");
    bread(2'd0, 4'h1, 8'h3C, "R2 ctrl B");
    check("R2 mode", mode_o, 4'hD);

    // R3 force strobes
    bwrite(2'd0, 4'h2, 8'hFF);
    check("R3 force all", force_o, 3'b111);
    @(negedge clk);
    check("R3 force one cycle", force_o, 3'b000);
    bread(2'd0, 4'h2, 8'h1F, "R3 ctrl C readback");
    bwrite(2'd0, 4'h2, 8'h40);
    check("R3 force channel 1", force_o, 3'b010);
    check("R3 ctrl C port", ctrl_c_o, 8'h00);

    // R4 atomic counter read
    cnt_live = 16'h1234;
    bread(2'd0, 4'h4, 8'h34, "R4 counter low");
    cnt_live = 16'hABCD;
    bread(2'd0, 4'h5, 8'h12, "R4 counter high from latch");

    // R5 counter write
    bwrite(2'd0, 4'h5, 8'h9A);
    check("R5 no load on high", cnt_wr_o, 0);
    bwrite(2'd0, 4'h4, 8'h7E);
    check("R5 load strobe", cnt_wr_o, 1);
    check("R5 load value", cnt_wdata_o, 16'h9A7E);
    @(negedge clk);
    check("R5 load one cycle", cnt_wr_o, 0);

    // R7 capture writes blocked (mode 13)
    bwrite(2'd0, 4'h7, 8'h55);
    bwrite(2'd0, 4'h6, 8'h66);
    check("R7 cap unchanged", cap_val_o, 16'h0000);
    bread(2'd0, 4'h5, 8'h9A, "R7 staging untouched");

    // R6 capture in mode 12
    bwrite(2'd0, 4'h0, 8'h00);
    bwrite(2'd0, 4'h1, 8'h18);
    check("R6 mode 12", mode_o, 4'hC);
    bwrite(2'd0, 4'h7, 8'hBE);
    bwrite(2'd0, 4'h6, 8'hEF);
    check("R6 cap value", cap_val_o, 16'hBEEF);
    bwrite(2'd0, 4'h5, 8'h00);
    bread(2'd0, 4'h6, 8'hEF, "R6 cap low");
    bread(2'd0, 4'h7, 8'hBE, "R6 cap high via latch");
    bwrite(2'd0, 4'h7, 8'h11);
    bwrite(2'd0, 4'h4, 8'h22);
    check("R6 shared latch into counter", cnt_wdata_o, 16'h1122);

    // R8 compare registers
    for (int k = 0; k < 3; k++) begin
      bwrite(2'd0, 4'(8 + 2*k), 8'(8'h10 + k));
      bwrite(2'd0, 4'(9 + 2*k), 8'(8'hC0 + k));
    end
    check("R8 cmp port", cmp_val_o, 48'hC212_C111_C010);
    bread(2'd0, 4'hB, 8'hC1, "R8 cmp1 high");
    bread(2'd0, 4'hC, 8'h12, "R8 cmp2 low");

    // R9 mask
    bwrite(2'd1, 4'h0, 8'hFF);
    check("R9 mask port", irq_mask_o, 8'h2F);
    bread(2'd1, 4'h0, 8'h2F, "R9 mask readback");

    // R10 flags
    flag_set = 8'h01;
    @(negedge clk);
    flag_set = 8'h00;
    check("R10 flag set", irq_flag_o, 8'h01);
    bwrite(2'd2, 4'h0, 8'h0C);
    check("R10 flag write", irq_flag_o, 8'h0C);
    check("R10 flag_wr pulse", flag_wr_o, 1);
    @(negedge clk);
    check("R10 flag_wr one cycle", flag_wr_o, 0);
    flag_set = 8'hFF;
    @(negedge clk);
    flag_set = 8'h00;
    check("R10 flag reserved", irq_flag_o, 8'h2F);

    // R11 unmapped
    bwrite(2'd0, 4'h3, 8'hFF);
    bread(2'd0, 4'h3, 8'h00, "R11 hole 0x3");
    bread(2'd0, 4'hE, 8'h00, "R11 hole 0xE");
    bwrite(2'd1, 4'h1, 8'h00);
    bwrite(2'd3, 4'h0, 8'h00);
    bwrite(2'd2, 4'h2, 8'h00);
    bread(2'd1, 4'h1, 8'h00, "R11 mask region hole");
    bread(2'd1, 4'h0, 8'h2F, "R11 mask untouched");
    bread(2'd2, 4'h0, 8'h2F, "R11 flag untouched");
    bread(2'd0, 4'h0, 8'h00, "R11 ctrl A untouched");
    bread(2'd0, 4'h1, 8'h18, "R11 ctrl B untouched");

    // R12 hold
    bread(2'd0, 4'h1, 8'h18, "R12 read");
    repeat (2) @(negedge clk);
    check("R12 rdata held", bus_rdata, 8'h18);

    @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule